// File: doc/BRIEF.md
# Serial In-System Programming Master

This block drives the serial programming port of a target microcontroller. It produces the serial clock, the data line toward the target and an active-low target reset, and it samples the data line coming back. Each programming command is one frame of four bytes. The host hands over all 32 bits at once, and the block shifts them out most significant bit first. At the same time it collects the 32 bits the target returns. When the frame ends it raises a one-cycle done pulse and presents the whole captured word, with the final returned byte on a separate output.

The serial clock is slow compared with the local clock. The host gives the ratio of local clock to target CPU clock, and a speed flag that is set when the target runs at 12 MHz or faster. Each half of the serial clock then lasts `ratio*3` local cycles for a slow target, or `ratio*4` for a fast one. That is one target cycle more than the minimum of 2 or 3. The target takes data on the rising serial clock edge and drives its reply after the falling edge. For that reason the block changes its output only while the clock is low, and it samples the reply in the last cycle before each rising edge.

After power-up the target reset and the serial clock stay low. An entry request drives reset high for a fixed number of cycles and then low again. The block then waits a programmable gap before it reports ready. Frames are accepted only while the block is ready. A verify step should treat a returned 0xFF as the erased value.

Top module: `isp_master`

## Requirements
- R1: After `rst_n` is released, the outputs are as follows: `tgt_rst_n`, `tgt_sck` and `tgt_mosi` are 0, `ready`, `busy` and `done` are 0, and `rx_word` is 0.
- R2: An accepted frame drives `instr` out on `tgt_mosi`, bit 31 first and bit 0 last. The bit is set when the frame is accepted and changes only in the cycle that `tgt_sck` falls. After the last bit it stays unchanged.
- R3: Each low phase and each high phase of `tgt_sck` lasts `L` local cycles. `L = r*3` when `fast_tgt` = 0 and `L = r*4` when `fast_tgt` = 1, where `r = clk_ratio`, and a `clk_ratio` of 0 counts as 1. `L` is latched when the frame is accepted. The frame starts with a low phase and has 32 low/high pairs.
- R4: `tgt_miso` is sampled at the clock edge where `tgt_sck` rises. Each sample is shifted into bit 0 of `rx_word`, so the first bit returned ends up at bit 31.
- R5: `done` is high for exactly one cycle, in the cycle where the last high phase ends and `tgt_sck` returns low. At that point `rx_word` holds the 32 returned bits and `rx_last` equals `rx_word[7:0]`.
- R6: An entry request is taken when the block is ready or has never been entered. `tgt_rst_n` then goes high for `RST_PULSE` cycles and returns low. After that, `ready` rises once `max(entry_gap,1)` further cycles have passed.
- R7: `busy` is high from the cycle after a frame is accepted through the last high phase. It is low in the done cycle. `req` is ignored while the block is busy or not ready.
- R8: If `entry_req` and `req` are high in the same ready cycle, the entry sequence starts and no frame starts.
- R9: `entry_req` is ignored while `busy` is high.
- R10: `tgt_sck` is low whenever `busy` is low, including power-up and the entry sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_ratio | input | RATIO_W | Local clock cycles per target CPU cycle (0 treated as 1) |
| fast_tgt | input | 1 | Target clock is 12 MHz or faster |
| entry_req | input | 1 | Start the reset pulse and entry delay |
| entry_gap | input | GAP_W | Local cycles to wait after the reset pulse |
| req | input | 1 | Start a frame |
| instr | input | 32 | Four instruction bytes, first byte in bits 31:24 |
| busy | output | 1 | Frame in progress |
| ready | output | 1 | Entry finished, frame may be requested |
| done | output | 1 | One-cycle end-of-frame pulse |
| rx_word | output | 32 | Captured returned bits |
| rx_last | output | 8 | Last returned byte |
| tgt_sck | output | 1 | Serial clock to the target |
| tgt_mosi | output | 1 | Serial data to the target |
| tgt_rst_n | output | 1 | Target reset, active low |
| tgt_miso | input | 1 | Serial data from the target |

## Verification
Two functions can coincide in one cycle: starting a frame and restarting the entry sequence. Both are provoked by raising `req` and `entry_req` together while the block is ready, and also by sending an entry request in the middle of a frame. A behavioural model in the bench counts elapsed cycles from each start event and predicts the serial clock, the data bits, reset, ready and busy on every clock. A dropped frame, a missing reset pulse or a frame cut short therefore shows up as a miscompare within a few cycles.

// File: rtl/isp_master.sv
module isp_master #(
  parameter int RATIO_W   = 8,
  parameter int GAP_W     = 16,
  parameter int RST_PULSE = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] clk_ratio,
  input  logic               fast_tgt,
  input  logic               entry_req,
  input  logic [GAP_W-1:0]   entry_gap,
  input  logic               req,
  input  logic [31:0]        instr,
  output logic               busy,
  output logic               ready,
  output logic               done,
  output logic [31:0]        rx_word,
  output logic [7:0]         rx_last,
  output logic               tgt_sck,
  output logic               tgt_mosi,
  output logic               tgt_rst_n,
  input  logic               tgt_miso
);
  localparam int PH_W  = RATIO_W + 3;
  localparam int PR_W  = $clog2(RST_PULSE + 1) + 1;
  localparam int MX_W  = (PH_W > GAP_W) ? PH_W : GAP_W;
  localparam int CNT_W = ((MX_W > PR_W) ? MX_W : PR_W) + 1;

  typedef enum logic [2:0] {S_OFF, S_PULSE, S_GAP, S_RDY, S_LO, S_HI} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [PH_W-1:0]  plen;
  logic [31:0]      sh, rx;
  logic [4:0]       bitn;
  logic             sck, mosi, rstq, dn;

  wire [RATIO_W-1:0] eff       = (clk_ratio == '0) ? RATIO_W'(1) : clk_ratio;
  wire [PH_W-1:0]    phase_new = PH_W'(eff) * PH_W'(fast_tgt ? 3'd4 : 3'd3);
  wire               ph_last   = (cnt == CNT_W'(plen - PH_W'(1)));
  wire               gap_end   = ((cnt + CNT_W'(1)) >= CNT_W'(entry_gap));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OFF; cnt <= '0; plen <= PH_W'(3); sh <= '0; rx <= '0;
      bitn <= '0; sck <= 1'b0; mosi <= 1'b0; rstq <= 1'b0; dn <= 1'b0;
    end else begin
      dn  <= 1'b0;
      cnt <= cnt + CNT_W'(1);
      case (st)
        S_OFF, S_RDY: begin
          cnt <= '0;
          if (entry_req) begin
            st   <= S_PULSE;
            rstq <= 1'b1;
          end else if (st == S_RDY && req) begin
            st   <= S_LO;
            plen <= phase_new;
            sh   <= instr;
            mosi <= instr[31];
            bitn <= '0;
          end
        end
        S_PULSE: if (cnt == CNT_W'(RST_PULSE - 1)) begin
          st <= S_GAP; rstq <= 1'b0; cnt <= '0;
        end
        S_GAP: if (gap_end) st <= S_RDY;
        S_LO: if (ph_last) begin
          sck <= 1'b1; rx <= {rx[30:0], tgt_miso}; st <= S_HI; cnt <= '0;
        end
        S_HI: if (ph_last) begin
          sck <= 1'b0; cnt <= '0;
          if (bitn == 5'd31) begin
            dn <= 1'b1; st <= S_RDY;
          end else begin
            bitn <= bitn + 5'd1;
            sh   <= {sh[30:0], 1'b0};
            mosi <= sh[30];
            st   <= S_LO;
          end
        end
        default: st <= S_OFF;
      endcase
    end
  end

  assign busy      = (st == S_LO) || (st == S_HI);
  assign ready     = (st == S_RDY);
  assign done      = dn;
  assign rx_word   = rx;
  assign rx_last   = rx[7:0];
  assign tgt_sck   = sck;
  assign tgt_mosi  = mosi;
  assign tgt_rst_n = rstq;
endmodule

// File: rtl/isp_master_chk.sv
module isp_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic ready,
  input logic done,
  input logic tgt_sck,
  input logic tgt_mosi,
  input logic tgt_rst_n
);
  // R10
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tgt_sck);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !tgt_sck && $past(tgt_sck)));
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sck |-> $stable(tgt_mosi));
  // R7
  busy_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tgt_rst_n);
  // R6
  ready_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!tgt_rst_n && !busy));
endmodule

bind isp_master isp_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ready(ready), .done(done),
  .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi), .tgt_rst_n(tgt_rst_n)
);

// File: tb/sim_isp_master.sv
`timescale 1ns/1ps
module sim_isp_master;
  localparam int RATIO_W = 8, GAP_W = 16, RST_PULSE = 16;

  logic clk = 0, rst_n = 0;
  logic [RATIO_W-1:0] clk_ratio = 1;
  logic fast_tgt = 0, entry_req = 0, req = 0, tgt_miso = 0;
  logic [GAP_W-1:0] entry_gap = 5;
  logic [31:0] instr = 0;
  logic busy, ready, done, tgt_sck, tgt_mosi, tgt_rst_n;
  logic [31:0] rx_word;
  logic [7:0] rx_last;

  always #5 clk = ~clk;

  isp_master #(.RATIO_W(RATIO_W), .GAP_W(GAP_W), .RST_PULSE(RST_PULSE)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_ratio(clk_ratio), .fast_tgt(fast_tgt),
    .entry_req(entry_req), .entry_gap(entry_gap), .req(req), .instr(instr),
    .busy(busy), .ready(ready), .done(done), .rx_word(rx_word), .rx_last(rx_last),
    .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi), .tgt_rst_n(tgt_rst_n), .tgt_miso(tgt_miso));

  int vectors = 0, miscompares = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // simple target: drives reply bits, advancing after each falling SCK
  logic [31:0] reply = 32'h0;
  int fidx = 0;
  logic prev_sck = 0;
  always @(negedge clk) begin
    if (!busy) fidx = 0;
    else if (prev_sck && !tgt_sck) fidx++;
    prev_sck = tgt_sck;
    tgt_miso = (fidx < 32) ? reply[31 - fidx] : 1'b0;
  end

  // behavioural reference: mode 0 off, 1 pulse, 2 gap, 3 ready, 4 frame
  int m_mode = 0, k = 0, m_L = 3;
  logic [31:0] m_word = 0, m_rx = 0;
  logic m_sck = 0, m_mosi = 0, m_rst = 0, m_done = 0;
  int gapv;

  always @(posedge clk) begin
    m_done = 0;
    if (!rst_n) begin
      m_mode = 0; k = 0; m_rx = 0; m_sck = 0; m_mosi = 0; m_rst = 0;
    end else begin
      case (m_mode)
        0, 3: begin
          if (entry_req) begin m_mode = 1; k = 0; m_rst = 1; end
          else if (m_mode == 3 && req) begin
            m_mode = 4; k = 0; m_word = instr;
            m_L = ((clk_ratio == 0) ? 1 : int'(clk_ratio)) * (fast_tgt ? 4 : 3);
            m_mosi = instr[31]; m_sck = 0;
          end
        end
        1: begin k++; if (k == RST_PULSE) begin m_mode = 2; k = 0; m_rst = 0; end end
        2: begin
          k++; gapv = (entry_gap == 0) ? 1 : int'(entry_gap);
          if (k >= gapv) m_mode = 3;
        end
        default: begin
          k++;
          if (k % m_L == 0 && (k / m_L) % 2 == 1) m_rx = {m_rx[30:0], tgt_miso};
          if (k == 64 * m_L) begin m_sck = 0; m_done = 1; m_mode = 3; end
          else begin
            m_sck  = ((k / m_L) % 2) == 1;
            m_mosi = m_word[31 - (k / m_L) / 2];
          end
        end
      endcase
    end
    #2;
    if (rst_n) begin
      chk(tgt_sck === m_sck, busy ? "R3 sck" : "R10 sck", 32'(tgt_sck), 32'(m_sck));
      chk(tgt_mosi === m_mosi, "R2 mosi", 32'(tgt_mosi), 32'(m_mosi));
      chk(tgt_rst_n === m_rst, "R6 tgt_rst_n", 32'(tgt_rst_n), 32'(m_rst));
      chk(ready === (m_mode == 3), "R6 ready", 32'(ready), 32'(m_mode == 3));
      chk(busy === (m_mode == 4), "R7 busy", 32'(busy), 32'(m_mode == 4));
      chk(done === m_done, "R5 done", 32'(done), 32'(m_done));
      chk(rx_word === m_rx, "R4 rx_word", rx_word, m_rx);
      chk(rx_last === m_rx[7:0], "R5 rx_last", 32'(rx_last), 32'(m_rx[7:0]));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] cmd, input logic [31:0] rep,
                       input logic [RATIO_W-1:0] r, input logic f);
    logic seen;
    seen = 0;
    @(negedge clk);
    reply = rep; clk_ratio = r; fast_tgt = f; instr = cmd; req = 1;
    @(negedge clk);
    req = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, "R5 done seen", 32'(seen), 32'd1);
    if (seen) chk(rx_word === rep, "R4 reply word", rx_word, rep);
    cyc(2);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    #2;
    chk(tgt_rst_n === 0 && tgt_sck === 0 && !ready && !busy && !done, "R1 reset state",
        {28'd0, tgt_rst_n, tgt_sck, ready, busy}, 32'd0);
    // R7: request before entry is ignored
    @(negedge clk); instr = 32'hDEADBEEF; req = 1;
    @(negedge clk); req = 0;
    cyc(2);
    chk(!busy && !tgt_sck, "R7 req before entry", 32'(busy), 32'd0);
    // R6: entry sequence
    @(negedge clk); entry_gap = 5; entry_req = 1;
    @(negedge clk); entry_req = 0;
    wait_ready();
    chk(ready, "R6 entered", 32'(ready), 32'd1);
    frame(32'hA5C30F81, 32'h12345678, 8'd1, 1'b0);
    frame(32'h3C00FF7E, 32'h9ABC_DE01, 8'd2, 1'b1);
    frame(32'h80000001, 32'hFFFFFFFF, 8'd0, 1'b0);
    chk(rx_last === 8'hFF, "R5 erased byte", 32'(rx_last), 32'hFF);
    // R7 + R9: req and entry_req while busy are ignored
    @(negedge clk); reply = 32'h0F0F1234; clk_ratio = 1; fast_tgt = 1; instr = 32'h5A5A5A5A; req = 1;
    @(negedge clk); req = 0;
    cyc(10);
    instr = 32'h00000000; req = 1; entry_req = 1;
    @(negedge clk); req = 0; entry_req = 0;
    cyc(2);
    chk(tgt_rst_n === 0 && busy, "R9 entry ignored while busy", 32'(tgt_rst_n), 32'd0);
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    chk(rx_word === 32'h0F0F1234, "R7 frame unaffected", rx_word, 32'h0F0F1234);
    cyc(2);
    // R8: collision in ready cycle, entry wins
    @(negedge clk); entry_gap = 0; instr = 32'hFFFF0000; req = 1; entry_req = 1;
    @(negedge clk); req = 0; entry_req = 0;
    #2;
    chk(!busy && tgt_rst_n === 1, "R8 entry wins", {30'd0, busy, tgt_rst_n}, 32'd1);
    wait_ready();
    frame(32'h12AB34CD, 32'h00000000, 8'd3, 1'b1);
    cyc(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule